// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit

This unit takes two single-precision IEEE-754 words and returns their sum or difference as a packed single-precision word. A control bit chosen with each request selects subtraction, which is carried out by inverting the sign of the second operand and then taking the ordinary addition path. Each operand is expanded into a sign, a biased exponent and a 32-bit working magnitude. That magnitude holds the 24-bit significand, with its leading one made explicit, followed by 8 guard bits. The magnitude with the lower exponent is shifted right to line up with the other. Every bit lost in that shift is folded into the lowest guard bit, which serves as the sticky bit. The two magnitudes are then combined, normalized one bit per cycle, and rounded to nearest with ties to even.

Operands flow in on a valid/ready pair. `in_ready` is high only while the unit is idle, and a request is taken on a rising edge where `in_valid` and `in_ready` are both high. The result flows out on a second valid/ready pair. After `out_valid` rises, it stays high and `out_result` and `out_trap` stay constant until a rising edge that sees `out_ready` high. No new request is taken until that edge, so holding `out_ready` low stalls the input side.

The unit does not compute with denormals, infinities or NaNs; it raises a trap for them instead. It also traps when the result exponent leaves the normal range. A trap never overwrites the result register. An inexact flag stays set from the first inexact result until reset. When `trap_en` is high, an inexact result also raises a trap.

Top module: `fp_addsub_unit`

## Requirements
- R1: An operand with exponent field (bits 30:23) equal to 255, or with exponent field 0 and a nonzero fraction (bits 22:0), makes the operation end with `out_trap`=1, and `out_result` keeps the value it had before.
- R2: With `in_sub`=1 the result equals `in_a` plus `in_b` with bit 31 (the sign) of `in_b` inverted.
- R3: The operand with the smaller exponent is shifted right by the exponent difference, and any nonzero bit shifted out is ORed into bit 0 of the 32-bit working magnitude. A difference of 32 or more leaves only that bit set.
- R4: When the effective signs are equal, the magnitudes are added. A carry out of the top bit shifts the sum right by one, keeps the sticky bit, and raises the exponent by one.
- R5: When the effective signs differ, the magnitudes are subtracted. On a borrow the magnitude is negated and the sign of the second (effective) operand is taken. The result is then normalized left, with the exponent falling by one per shifted bit.
- R6: If both operands are zero, the result is 0x80000000 only when both effective signs are negative, and 0x00000000 otherwise. If exactly one operand is zero, the result is the other operand with its effective sign.
- R7: A nonzero pair whose magnitudes cancel exactly gives 0x00000000.
- R8: Rounding looks at the 8 guard bits G below the 24-bit significand, whose least significant bit is L. It rounds up when G > 0x80, or when G = 0x80 and L = 1. A carry out of the significand gives significand 1.0 and exponent plus one.
- R9: A rounded biased exponent above 254 or below 1 gives `out_trap`=1.
- R10: A nonzero G sets `inexact_flag`, which stays set until reset. With `trap_en`=1, an inexact result also gives `out_trap`=1 and leaves `out_result` unchanged.
- R11: `in_ready` is low from acceptance until the result is taken. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_result` and `out_trap` hold their values.
- R12: After reset `in_ready`=1, `out_valid`=0, `out_result`=0 and `inexact_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_sub | input | 1 | 1 = subtract in_b from in_a |
| trap_en | input | 1 | Inexact results raise a trap |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Packed result (kept on trap) |
| out_trap | output | 1 | Operation trapped |
| inexact_flag | output | 1 | Inexact result seen since reset |

## Verification
The bench builds the unit with its default parameters: an 8-bit exponent, a 23-bit fraction and 8 guard bits. This makes the rounding ties exact at a 24-bit exponent gap. It also lets exponent gaps of 32 or more reach the collapse path, and it pushes a 24-place renormalization and exponents at both ends of the range into the trap logic. The directed part holds `out_ready` low to show back-pressure and uses `trap_en` to turn inexact results into traps.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_OUT  = 2'd2
  } fpas_state_e;
endpackage

// File: rtl/fpas_unpack.sv
module fpas_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRD_W = 8,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1 + GRD_W
) (
  input  logic [W-1:0]     word,
  input  logic             flip,
  output logic             sign,
  output logic [EXP_W-1:0] expo,
  output logic [SIG_W-1:0] mag,
  output logic             is_zero,
  output logic             bad
);
  logic [MAN_W-1:0] frac;
  logic             e_zero, e_ones;

  assign frac    = word[MAN_W-1:0];
  assign expo    = word[W-2:MAN_W];
  assign sign    = word[W-1] ^ flip;
  assign e_zero  = (expo == '0);
  assign e_ones  = (expo == '1);
  assign is_zero = e_zero && (frac == '0);
  assign bad     = e_ones || (e_zero && (frac != '0));
  assign mag     = e_zero ? '0 : {1'b1, frac, {GRD_W{1'b0}}};
endmodule

// File: rtl/fpas_align_add.sv
module fpas_align_add #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 32,
  localparam int XW   = EXP_W + 2
) (
  input  logic             sa,
  input  logic [EXP_W-1:0] ea,
  input  logic [SIG_W-1:0] ma,
  input  logic             sb,
  input  logic [EXP_W-1:0] eb,
  input  logic [SIG_W-1:0] mb,
  output logic             sign,
  output logic [XW-1:0]    expo,
  output logic [SIG_W-1:0] mag
);
  logic             a_big, s_big, s_small, lost;
  logic [EXP_W-1:0] e_big, diff;
  logic [SIG_W-1:0] m_big, m_small, m_al;
  logic [SIG_W:0]   sum, dif;

  always_comb begin
    a_big   = (ea >= eb);
    s_big   = a_big ? sa : sb;
    s_small = a_big ? sb : sa;
    e_big   = a_big ? ea : eb;
    m_big   = a_big ? ma : mb;
    m_small = a_big ? mb : ma;
    diff    = a_big ? (ea - eb) : (eb - ea);
    if (int'(diff) >= SIG_W) begin
      lost = (m_small != '0);
      m_al = '0;
    end else begin
      lost = |(m_small & ~({SIG_W{1'b1}} << diff));
      m_al = m_small >> diff;
    end
    m_al[0] = m_al[0] | lost;
    sum  = {1'b0, m_big} + {1'b0, m_al};
    dif  = {1'b0, m_big} - {1'b0, m_al};
    expo = {2'b00, e_big};
    if (s_big == s_small) begin
      sign = s_big;
      if (sum[SIG_W]) begin
        mag  = sum[SIG_W:1];
        mag[0] = mag[0] | sum[0];
        expo = {2'b00, e_big} + XW'(1);
      end else begin
        mag = sum[SIG_W-1:0];
      end
    end else if (dif[SIG_W]) begin
      sign = s_small;
      mag  = -dif[SIG_W-1:0];
    end else begin
      sign = s_big;
      mag  = dif[SIG_W-1:0];
    end
  end
endmodule

// File: rtl/fpas_round_pack.sv
module fpas_round_pack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRD_W = 8,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1 + GRD_W,
  localparam int XW    = EXP_W + 2,
  localparam int EMAX  = (2 ** EXP_W) - 2
) (
  input  logic             sign,
  input  logic [XW-1:0]    expo,
  input  logic [SIG_W-1:0] mag,
  output logic [W-1:0]     word,
  output logic             inexact,
  output logic             range_err
);
  localparam logic [GRD_W-1:0] HALF = GRD_W'(1) << (GRD_W - 1);
  logic [GRD_W-1:0] grd;
  logic             lsb, up;
  logic [MAN_W+1:0] sig_r;
  logic [XW-1:0]    exp_r;

  always_comb begin
    grd     = mag[GRD_W-1:0];
    lsb     = mag[GRD_W];
    up      = (grd > HALF) || ((grd == HALF) && lsb);
    inexact = (grd != '0);
    sig_r   = {1'b0, mag[SIG_W-1:GRD_W]} + {{(MAN_W+1){1'b0}}, up};
    exp_r   = expo + {{(XW-1){1'b0}}, sig_r[MAN_W+1]};
    range_err = (int'($signed(exp_r)) > EMAX) || (int'($signed(exp_r)) < 1);
    word    = {sign, exp_r[EXP_W-1:0], sig_r[MAN_W-1:0]};
  end
endmodule

// File: rtl/fp_addsub_unit.sv
module fp_addsub_unit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRD_W = 8,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1 + GRD_W,
  localparam int XW    = EXP_W + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_sub,
  input  logic         trap_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_trap,
  output logic         inexact_flag
);
  import fpas_pkg::*;

  fpas_state_e      state;
  logic             acc;
  logic             op_s   [2];
  logic [EXP_W-1:0] op_e   [2];
  logic [SIG_W-1:0] op_m   [2];
  logic             op_z   [2];
  logic             op_bad [2];
  logic [W-1:0]     op_w   [2];

  assign op_w[0] = in_a;
  assign op_w[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_unp
    fpas_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_unp (
      .word(op_w[i]), .flip((i == 1) && in_sub), .sign(op_s[i]),
      .expo(op_e[i]), .mag(op_m[i]), .is_zero(op_z[i]), .bad(op_bad[i]));
  end

  logic             c_sign;
  logic [XW-1:0]    c_exp;
  logic [SIG_W-1:0] c_mag;

  fpas_align_add #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_add (
    .sa(op_s[0]), .ea(op_e[0]), .ma(op_m[0]),
    .sb(op_s[1]), .eb(op_e[1]), .mb(op_m[1]),
    .sign(c_sign), .expo(c_exp), .mag(c_mag));

  logic             n_sign;
  logic [XW-1:0]    n_exp;
  logic [SIG_W-1:0] n_mag;
  logic [W-1:0]     rp_word;
  logic             rp_inexact, rp_range;

  fpas_round_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_rnd (
    .sign(n_sign), .expo(n_exp), .mag(n_mag),
    .word(rp_word), .inexact(rp_inexact), .range_err(rp_range));

  assign acc       = in_valid && in_ready;
  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      n_sign       <= 1'b0;
      n_exp        <= '0;
      n_mag        <= '0;
      out_result   <= '0;
      out_trap     <= 1'b0;
      inexact_flag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (acc) begin
          out_trap <= 1'b0;
          state    <= ST_OUT;
          if (op_bad[0] || op_bad[1]) begin
            out_trap <= 1'b1;
          end else if (op_z[0] && op_z[1]) begin
            out_result <= {op_s[0] && op_s[1], {(W-1){1'b0}}};
          end else if (op_z[0]) begin
            out_result <= {op_s[1], in_b[W-2:0]};
          end else if (op_z[1]) begin
            out_result <= in_a;
          end else if (c_mag == '0) begin
            out_result <= '0;
          end else begin
            n_sign <= c_sign;
            n_exp  <= c_exp;
            n_mag  <= c_mag;
            state  <= ST_NORM;
          end
        end
        ST_NORM: if (n_mag[SIG_W-1]) begin
          inexact_flag <= inexact_flag | rp_inexact;
          out_trap     <= rp_range || (rp_inexact && trap_en);
          if (!(rp_range || (rp_inexact && trap_en))) out_result <= rp_word;
          state <= ST_OUT;
        end else begin
          n_mag <= n_mag << 1;
          n_exp <= n_exp - XW'(1);
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_trap)));

  // R10
  inexact_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_flag |=> inexact_flag);

  // R1
  bad_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op_bad[0] || op_bad[1])) |=> (out_valid && out_trap && $stable(out_result)));

  // R9
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_trap) |-> (out_result[W-2:MAN_W] != '1));

  // R7
  norm_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM) |-> (n_mag != '0));
endmodule

// File: tb/tb_fp_addsub_unit.sv
module tb_fp_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sub = 1'b0, trap_en = 1'b0, out_ready = 1'b1;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_ready, out_valid, out_trap, inexact_flag;
  logic [31:0] out_result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fp_addsub_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .trap_en(trap_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_trap(out_trap), .inexact_flag(inexact_flag));

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        sub;
    logic [31:0] res;
    logic        trap;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 4'd4},  // R4 1+1
    '{32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 4'd2},  // R2 1-1
    '{32'h3F800000, 32'hBF800000, 1'b0, 32'h00000000, 1'b0, 4'd7},  // R7 cancel
    '{32'h40000000, 32'h3F800000, 1'b1, 32'h3F800000, 1'b0, 4'd2},  // R2 2-1
    '{32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, 1'b0, 4'd5},  // R5 borrow
    '{32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 1'b0, 4'd4},  // R4 carry
    '{32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0, 4'd6},  // R6
    '{32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 1'b0, 4'd6},  // R6
    '{32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 1'b0, 4'd6},  // R6
    '{32'h80000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0, 4'd6},  // R6
    '{32'h00000000, 32'h3F800000, 1'b1, 32'hBF800000, 1'b0, 4'd6},  // R6
    '{32'h3F800000, 32'h00000000, 1'b0, 32'h3F800000, 1'b0, 4'd6},  // R6
    '{32'h3F800000, 32'h2B800000, 1'b0, 32'h3F800000, 1'b0, 4'd3},  // R3 gap 40
    '{32'h3F800000, 32'h34000001, 1'b0, 32'h3F800001, 1'b0, 4'd3},  // R3 gap 23 sticky
    '{32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 4'd8},  // R8 tie even
    '{32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 4'd8},  // R8 tie odd
    '{32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 4'd8},  // R8 above half
    '{32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 4'd8},  // R8 carry
    '{32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 1'b0, 4'd5},  // R5 renorm 24
    '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h00000000, 1'b1, 4'd9},  // R9 overflow
    '{32'h00800000, 32'h00800001, 1'b1, 32'h00000000, 1'b1, 4'd9},  // R9 underflow
    '{32'h7F800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b1, 4'd1},  // R1 inf
    '{32'h00000001, 32'h3F800000, 1'b0, 32'h00000000, 1'b1, 4'd1},  // R1 denormal
    '{32'h3F800000, 32'h7FC00000, 1'b1, 32'h00000000, 1'b1, 4'd1}   // R1 NaN
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_out();
    for (int k = 0; k < 200 && !out_valid; k++) @(negedge clk);
    if (!out_valid) begin
      checks++; fails++;
      $display("FAIL R11 actual=no out_valid expected=out_valid");
    end
  endtask

  // Issues one request; leaves with the output visible (sampled at a negedge).
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_out();
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12 out_result", out_result, 32'd0);
    chk("R12 inexact_flag", {31'd0, inexact_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 exact result leaves the flag clear
    issue(32'h3FC00000, 32'h40200000, 1'b0);
    chk("R10 exact flag", {31'd0, inexact_flag}, 32'd0);
    drain();

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].a, TBL[i].b, TBL[i].sub);
      chk($sformatf("R%0d trap row %0d", TBL[i].req, i), {31'd0, out_trap}, {31'd0, TBL[i].trap});
      if (!TBL[i].trap)
        chk($sformatf("R%0d result row %0d", TBL[i].req, i), out_result, TBL[i].res);
      drain();
    end
    chk("R10 sticky flag set", {31'd0, inexact_flag}, 32'd1);

    // R1 unsupported operand keeps the previous result
    issue(32'h3F800000, 32'h3F800000, 1'b0);
    drain();
    issue(32'hFF800000, 32'h3F800000, 1'b0);
    chk("R1 trap", {31'd0, out_trap}, 32'd1);
    chk("R1 result kept", out_result, 32'h40000000);
    drain();

    // R10 trap enable turns inexact into a trap, result kept
    trap_en = 1'b1;
    issue(32'h3F800000, 32'h2B800000, 1'b0);
    chk("R10 inexact trap", {31'd0, out_trap}, 32'd1);
    chk("R10 result kept", out_result, 32'h40000000);
    drain();
    issue(32'h3F800000, 32'h3F800000, 1'b0);
    chk("R10 exact no trap", {31'd0, out_trap}, 32'd0);
    drain();
    trap_en = 1'b0;

    // R11 back-pressure
    out_ready = 1'b0;
    issue(32'h3F800000, 32'h3F7FFFFF, 1'b1);
    held = out_result;
    chk("R11 busy in_ready", {31'd0, in_ready}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R11 hold valid", {31'd0, out_valid}, 32'd1);
    chk("R11 hold result", out_result, held);
    chk("R11 hold in_ready", {31'd0, in_ready}, 32'd0);
    chk("R5 result under stall", out_result, 32'h33800000);
    drain();
    chk("R11 released", {31'd0, out_valid}, 32'd0);
    chk("R11 ready again", {31'd0, in_ready}, 32'd1);

    finish_run();
  end
endmodule